// File: doc/BRIEF.md
# Synchronous Bus Frame Transmitter

This block places one frame at a time onto a shared serial bus whose bit clock comes from somewhere else on the bus. It has no bit timer of its own. It brings the incoming bus clock into the system clock domain and detects each rising edge. On every detected edge it launches exactly one bit.

A frame is built in this order:
- an opening delimiter byte;
- the payload, taken byte by byte from a ready/valid source;
- a 16-bit check value;
- a closing delimiter byte.

A zero is inserted after every run of five ones in the payload and check value, so the delimiter pattern cannot occur inside the frame. The block also drives the line driver's enable. The enable rises with the first delimiter bit and falls on the bus edge that follows the last one, so the driver holds the shared wire only while the frame is on it.

A user pulses `start` while the block is idle. The user then presents payload bytes, LSB first on the wire, and marks the final byte with `in_last`. `busy` reports that a frame is in progress.

Top module: `sfx_frame_tx`

## Requirements
- R1: During and after synchronous reset, with no start given, `tx_oe`=0, `busy`=0, `in_ready`=0 and `tx_bit`=1.
- R2: A `start` pulse while idle sets `busy` on the next clock. On the next bus clock rising edge, `tx_oe` rises together with the first bit of the opening delimiter 0x7E.
- R3: Exactly one bit is launched per bus clock rising edge, with no gaps. Every byte goes out least-significant bit first. `tx_bit` and `tx_oe` change only on the third system clock after a bus clock rise has been captured.
- R4: After five consecutive 1 bits among payload and check bits, a single 0 is inserted. The run count carries across byte boundaries. An insertion due after the last check bit is sent before the closing delimiter. Delimiter bits are never stuffed and do not count toward a run.
- R5: The check value is the reflected CRC-16 with polynomial 0x1021, processed LSB first, with initial value 0xFFFF and the result inverted. It covers only the payload bytes and is sent low byte first. For the ASCII payload "123456789" it is 0x906E.
- R6: The closing delimiter 0x7E directly follows the check value. On the next bus clock edge `tx_oe` falls, and `busy` falls in the same system clock cycle.
- R7: A byte is taken on a clock where `in_valid` and `in_ready` are both 1. After a byte flagged `in_last` has been taken, `in_ready` stays 0 until the next frame.
- R8: If no byte is held when the next payload byte is due, the payload ends there and the check value follows. With no byte at all, the frame is the delimiter, 16 zero bits (check value 0x0000) and the delimiter.
- R9: A `start` pulse while `busy` is 1 has no effect: the frame in flight is unchanged, and no second frame follows.
- R10: Whenever `tx_oe` is 0, `tx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Externally supplied bus bit clock, asynchronous |
| start | input | 1 | Start-of-frame command pulse |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Block accepts a payload byte this clock |
| tx_bit | output | 1 | Serial line data |
| tx_oe | output | 1 | Line driver output-enable |
| busy | output | 1 | Frame in progress |

## Verification
Zero insertion and the start of the closing delimiter can fall on the same bus edge. This happens when the last check bits complete a run of five ones, so the inserted zero must come out before the delimiter, and the enable must still drop on the edge that follows the delimiter. The bench provokes this collision by sweeping every single-byte payload and adding runs of 0xFF bytes. Together these drive check values that end in long runs of ones. It judges each captured line stream against a bit stream built arithmetically from the payload, comparing bit for bit, including total length and the position of the enable release.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN,
    PH_DATA,
    PH_CRCL,
    PH_CRCH,
    PH_CLOSE,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/sfx_edge_detect.sv
module sfx_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b0;
      else     sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sfx_crc_bit.sv
module sfx_crc_bit #(
  parameter int          WIDTH = 16,
  parameter logic [15:0] POLY  = 16'h8408,
  parameter logic [15:0] INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] crc_q,
  output logic [WIDTH-1:0] crc_next
);
  logic fb;

  assign fb       = crc_q[0] ^ bit_in;
  assign crc_next = (crc_q >> 1) ^ (fb ? POLY[WIDTH-1:0] : '0);

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= INIT[WIDTH-1:0];
    else if (en)      crc_q <= crc_next;
  end
endmodule

// File: rtl/sfx_run_counter.sv
module sfx_run_counter #(
  parameter int RUN_LEN = 5,
  localparam int ONES_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  input  logic bit_in,
  output logic at_limit
);
  logic [ONES_W-1:0] ones_q;

  always_ff @(posedge clk) begin
    if (rst || clear) ones_q <= '0;
    else if (en)      ones_q <= bit_in ? ones_q + 1'b1 : '0;
  end

  assign at_limit = (ones_q == ONES_W'(RUN_LEN));
endmodule

// File: rtl/sfx_frame_tx.sv
module sfx_frame_tx
  import sfx_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          RUN_LEN     = 5,
  parameter logic [7:0]  FLAG        = 8'h7E,
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_clk,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       tx_bit,
  output logic       tx_oe,
  output logic       busy
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int CRC_W  = 16;

  phase_e            phase_q;
  logic [BYTE_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] hold_q;
  logic              hold_vld_q, hold_last_q, fed_last_q, cur_last_q;
  logic              tx_bit_q, tx_oe_q, busy_q;

  logic              bus_tick, stuff_now, launch, take_in, byte_end, take_next;
  logic              crc_en, run_en, run_clear, in_data_phase;
  logic [CRC_W-1:0]  crc_q, crc_next, crc_fin;

  sfx_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(bus_clk), .rise_o(bus_tick)
  );

  assign in_data_phase = (phase_q == PH_DATA);
  assign launch    = start & (phase_q == PH_IDLE);
  assign crc_en    = bus_tick & ~stuff_now & in_data_phase;
  assign run_en    = bus_tick & ~stuff_now &
                     (in_data_phase || phase_q == PH_CRCL || phase_q == PH_CRCH);
  assign run_clear = launch | (bus_tick & stuff_now);

  sfx_crc_bit #(.WIDTH(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst(rst), .clear(launch), .en(crc_en), .bit_in(sreg_q[0]),
    .crc_q(crc_q), .crc_next(crc_next)
  );

  sfx_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst(rst), .clear(run_clear), .en(run_en), .bit_in(sreg_q[0]),
    .at_limit(stuff_now)
  );

  assign crc_fin   = in_data_phase ? crc_next : crc_q;
  assign byte_end  = (cnt_q == CNT_W'(BYTE_W - 1));
  assign take_next = hold_vld_q & ~(in_data_phase & cur_last_q);
  assign in_ready  = busy_q & ~hold_vld_q & ~fed_last_q & ~bus_tick &
                     (phase_q == PH_OPEN || in_data_phase);
  assign take_in   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      sreg_q      <= '0;
      cnt_q       <= '0;
      hold_q      <= '0;
      hold_vld_q  <= 1'b0;
      hold_last_q <= 1'b0;
      fed_last_q  <= 1'b0;
      cur_last_q  <= 1'b0;
      tx_bit_q    <= 1'b1;
      tx_oe_q     <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      if (take_in) begin
        hold_q      <= in_data;
        hold_vld_q  <= 1'b1;
        hold_last_q <= in_last;
        fed_last_q  <= in_last;
      end
      if (launch) begin
        phase_q    <= PH_OPEN;
        busy_q     <= 1'b1;
        sreg_q     <= FLAG;
        cnt_q      <= '0;
        hold_vld_q <= 1'b0;
        fed_last_q <= 1'b0;
        cur_last_q <= 1'b0;
      end else if (bus_tick && phase_q != PH_IDLE) begin
        if (phase_q == PH_DONE) begin
          tx_oe_q  <= 1'b0;
          tx_bit_q <= 1'b1;
          busy_q   <= 1'b0;
          phase_q  <= PH_IDLE;
        end else begin
          tx_oe_q <= 1'b1;
          if (stuff_now) begin
            tx_bit_q <= 1'b0;
          end else begin
            tx_bit_q <= sreg_q[0];
            sreg_q   <= sreg_q >> 1;
            cnt_q    <= cnt_q + 1'b1;
            if (byte_end) begin
              unique case (phase_q)
                PH_OPEN, PH_DATA: begin
                  if (take_next) begin
                    sreg_q     <= hold_q;
                    hold_vld_q <= 1'b0;
                    cur_last_q <= hold_last_q;
                    phase_q    <= PH_DATA;
                  end else begin
                    sreg_q  <= ~crc_fin[7:0];
                    phase_q <= PH_CRCL;
                  end
                end
                PH_CRCL: begin
                  sreg_q  <= ~crc_q[15:8];
                  phase_q <= PH_CRCH;
                end
                PH_CRCH: begin
                  sreg_q  <= FLAG;
                  phase_q <= PH_CLOSE;
                end
                PH_CLOSE: phase_q <= PH_DONE;
                default:  phase_q <= PH_IDLE;
              endcase
            end
          end
        end
      end
    end
  end

  assign tx_bit = tx_bit_q;
  assign tx_oe  = tx_oe_q;
  assign busy   = busy_q;
endmodule

// File: rtl/sfx_frame_tx_chk.sv
module sfx_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic busy,
  input logic tx_oe,
  input logic tx_bit,
  input logic in_ready
);
  // R10: the line rests high while the driver is off
  assert_quiet_line_R10: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> tx_bit);

  // R3: line outputs move only after a captured bus edge
  assert_launch_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(tx_bit) && $stable(tx_oe)));

  // R6: the driver is never enabled outside a frame
  assert_oe_inside_busy_R6: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> busy);

  // R6: busy and the driver enable are released together
  assert_release_together_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(tx_oe));

  // R7: bytes are only requested inside a frame
  assert_ready_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  // R2: the driver turns on only after the frame was started
  assert_oe_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> $past(busy));
endmodule

bind sfx_frame_tx sfx_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .tick(bus_tick), .busy(busy),
  .tx_oe(tx_oe), .tx_bit(tx_bit), .in_ready(in_ready)
);

// File: tb/sfx_frame_tx_tb.sv
module sfx_frame_tx_tb;
  logic       clk = 1'b0, rst = 1'b1, bus_clk = 1'b0, start = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic       in_ready, tx_bit, tx_oe, busy;

  int n_vec = 0, n_bad = 0, ones_m = 0;
  logic       exp_q[$];
  logic       got_q[$];
  logic [7:0] pay_q[$];

  sfx_frame_tx u_dut (
    .clk(clk), .rst(rst), .bus_clk(bus_clk), .start(start),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit), .tx_oe(tx_oe), .busy(busy)
  );

  always #5 clk = ~clk;

  initial forever begin
    repeat (4) @(posedge clk);
    #1 bus_clk = ~bus_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ pay_q[i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic add_byte(input logic [7:0] b, input bit stuffed);
    for (int k = 0; k < 8; k++) begin
      exp_q.push_back(b[k]);
      if (stuffed) begin
        if (b[k]) ones_m++;
        else ones_m = 0;
        if (ones_m == 5) begin
          exp_q.push_back(1'b0);
          ones_m = 0;
        end
      end
    end
  endtask

  // sends the first n bytes of pay_q; give_last marks the final one
  task automatic run_frame(input int n, input bit give_last, input bit poke);
    logic [15:0] c = crc_of(n);
    exp_q.delete(); got_q.delete(); ones_m = 0;
    add_byte(8'h7E, 1'b0);
    for (int i = 0; i < n; i++) add_byte(pay_q[i], 1'b1);
    add_byte(c[7:0], 1'b1);
    add_byte(c[15:8], 1'b1);
    add_byte(8'h7E, 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    fork
      begin : feeder
        for (int i = 0; i < n; i++) begin
          in_valid = 1'b1; in_data = pay_q[i];
          in_last = give_last && (i == n - 1);
          while (!in_ready) @(negedge clk);
          @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        if (give_last && n > 0)
          chk(in_ready === 1'b0, "R7 ready after last", int'(in_ready), 0);
      end
      begin : recorder
        bit seen = 0;
        forever begin
          @(negedge bus_clk); #1;
          if (tx_oe) begin
            seen = 1;
            got_q.push_back(tx_bit);
            if (!busy) chk(1'b0, "R6 busy while driving", 0, 1);
          end else if (seen) begin
            chk(busy === 1'b0, "R6 busy released with oe", int'(busy), 0);
            break;
          end else if (tx_bit !== 1'b1) begin
            chk(1'b0, "R10 idle line level", int'(tx_bit), 1);
          end
        end
      end
      begin : poker
        if (poke) begin
          wait (got_q.size() >= 12);
          @(negedge clk) start = 1'b1;
          @(negedge clk) start = 1'b0;
        end
      end
    join
    chk(got_q.size() == exp_q.size(), "R4 stream length", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      chk(got_q[i] === exp_q[i], "R3 line bit", int'(got_q[i]), int'(exp_q[i]));
      if (got_q[i] !== exp_q[i]) break;
    end
    if (got_q.size() >= 8) begin
      logic [7:0] head, tail;
      for (int k = 0; k < 8; k++) begin
        head[k] = got_q[k];
        tail[k] = got_q[got_q.size() - 8 + k];
      end
      chk(head == 8'h7E, "R2 opening delimiter", head, 8'h7E);
      chk(tail == 8'h7E, "R6 closing delimiter", tail, 8'h7E);
    end
    repeat (24) @(negedge clk);
    chk(tx_oe === 1'b0 && busy === 1'b0, poke ? "R9 no second frame" : "R6 idle after frame",
        {tx_oe, busy}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(tx_oe === 0 && busy === 0 && in_ready === 0 && tx_bit === 1,
        "R1 reset state", {tx_oe, busy, in_ready, tx_bit}, 4'b0001);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(tx_oe === 0 && busy === 0 && in_ready === 0 && tx_bit === 1,
        "R1 after reset", {tx_oe, busy, in_ready, tx_bit}, 4'b0001);

    // R5: known check vector
    pay_q.delete();
    for (int i = 0; i < 9; i++) pay_q.push_back(8'h31 + 8'(i));
    chk(crc_of(9) == 16'h906E, "R5 reference check value", crc_of(9), 16'h906E);
    run_frame(9, 1'b1, 1'b0);

    // R3/R4: every single-byte payload
    for (int v = 0; v < 256; v++) begin
      pay_q.delete();
      pay_q.push_back(8'(v));
      run_frame(1, 1'b1, 1'b0);
    end

    // R4: long runs of ones and a run spanning a byte boundary
    pay_q.delete();
    repeat (4) pay_q.push_back(8'hFF);
    pay_q.push_back(8'hF8); pay_q.push_back(8'h1F);
    run_frame(6, 1'b1, 1'b0);

    // R8: empty payload and mid-frame underrun
    pay_q.delete();
    run_frame(0, 1'b0, 1'b0);
    pay_q.push_back(8'hA5); pay_q.push_back(8'h3C);
    run_frame(2, 1'b0, 1'b0);

    // R9: start while busy is ignored
    pay_q.delete();
    pay_q.push_back(8'h12); pay_q.push_back(8'h7E); pay_q.push_back(8'hFE);
    run_frame(3, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule